// File: doc/BRIEF.md
# Indexed Colour Palette with Byte-Lane Register Port

This block is an indexed colour lookup table with a register port on the host side that follows the style of a classic video DAC. The host writes an entry number into a pointer register. It then writes the red, green and blue components of that entry one after another through a colour-data register. Every value travels in the most significant byte of a 32-bit bus word. A second register, which shares the same pointer, reaches four 8-bit control registers: a pixel read mask, a blink mask, an overlay command byte and a test byte.

On the pixel side, the block takes an 8-bit index each clock. It ANDs the index with the read mask, looks it up in the table, and outputs a 24-bit RGB word one clock later. A video-enable input travels with the index. When video is disabled, the output is forced to black.

Top module: `palette_dac`

## Requirements
- R1: After reset the control outputs read mask = 0xFF, blink mask = 0x00, command = 0x73 and test = 0x00, and `rgb_out` is 0.
- R2: Only bits 31:24 of `bus_wdata` carry a value. Bits 23:0 have no effect on any register or table entry.
- R3: `bus_sel` = 0 writes the pointer and `bus_sel` = 1 writes colour data. After a pointer write, three colour-data writes load red, green and blue of the pointed entry, in that order. The entry then reads back on `rgb_out` as {red[23:16], green[15:8], blue[7:0]}.
- R4: The blue write advances the pointer by one, wrapping from 255 to 0, and the next colour write is red again. Consecutive entries therefore load without a new pointer write.
- R5: A pointer write always restarts the component sequence at red. Partially written components never reach the table.
- R6: A write with `bus_sel` = 2 loads the control register selected by the pointer: 4 = read mask, 5 = blink mask, 6 = command, 7 = test. Any other pointer value makes the write have no effect.
- R7: The pixel index is ANDed with the read mask before the lookup.
- R8: The lookup takes one clock. `rgb_out` changes only at the clock edge after `pix_idx` changes.
- R9: When `video_en` is low at an edge, `rgb_out` is 0 (black) from that edge until the next edge, whatever the table holds.
- R10: A lookup of an entry in the same clock as the blue write to that entry returns the entry's old value. The new value appears on the next lookup.
- R11: A write with `bus_sel` = 3 has no effect on the pointer, the component sequence, the table or the control registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe, one write per asserted cycle |
| bus_sel | input | 2 | Register select: 0 pointer, 1 colour data, 2 control, 3 unused |
| bus_wdata | input | 32 | Write data; value in bits 31:24 |
| pix_idx | input | 8 | Pixel palette index |
| video_en | input | 1 | Video enable; low blanks the output |
| rgb_out | output | 24 | Looked-up colour {R,G,B}, one clock after the index |
| ctl_rmask | output | 8 | Current pixel read mask |
| ctl_blink | output | 8 | Current blink mask |
| ctl_cmd | output | 8 | Current overlay command byte |
| ctl_test | output | 8 | Current test byte |

## Verification
Two functions can land in the same clock: the blue write that commits an entry and a pixel lookup of that same entry. The bench provokes this by driving the blue write and the matching `pix_idx` on the same edge. It expects the old colour right after that edge and the new colour one edge later. It also sweeps all 256 entries with arithmetically generated colours, runs the pointer past 255, and masks indices through the read mask.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_CMAP = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } bus_sel_e;

  typedef enum logic [1:0] {
    C_RED = 2'd0,
    C_GRN = 2'd1,
    C_BLU = 2'd2
  } comp_e;

  localparam int CTL_BASE  = 4;
  localparam int CTL_COUNT = 4;

  // Reset value of control register k (pointer CTL_BASE + k).
  function automatic logic [7:0] ctl_init(input int k);
    case (k)
      0:       return 8'hFF;
      2:       return 8'h73;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/pal_regport.sv
module pal_regport
  import pal_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int COMP_W = 8,
  parameter int IDX_W  = 8,
  localparam int RGB_W = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_sel,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_waddr,
  output logic [RGB_W-1:0]  ram_wdata,
  output logic [COMP_W-1:0] rmask,
  output logic [COMP_W-1:0] blink,
  output logic [COMP_W-1:0] cmd,
  output logic [COMP_W-1:0] test
);
  logic [COMP_W-1:0] lane;
  logic [IDX_W-1:0]  ptr_q;
  comp_e             comp_q;
  logic [COMP_W-1:0] red_q, grn_q;
  logic [COMP_W-1:0] ctl_q [CTL_COUNT];
  logic              wr_ptr, wr_cmap, wr_ctrl;

  assign lane    = bus_wdata[BUS_W-1 -: COMP_W];
  assign wr_ptr  = bus_wr && (bus_sel == SEL_PTR);
  assign wr_cmap = bus_wr && (bus_sel == SEL_CMAP);
  assign wr_ctrl = bus_wr && (bus_sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      comp_q <= C_RED;
      red_q  <= '0;
      grn_q  <= '0;
    end else if (wr_ptr) begin
      ptr_q  <= IDX_W'(lane);
      comp_q <= C_RED;
    end else if (wr_cmap) begin
      case (comp_q)
        C_RED: begin
          red_q  <= lane;
          comp_q <= C_GRN;
        end
        C_GRN: begin
          grn_q  <= lane;
          comp_q <= C_BLU;
        end
        default: begin
          ptr_q  <= ptr_q + 1'b1;
          comp_q <= C_RED;
        end
      endcase
    end
  end

  assign ram_we    = wr_cmap && (comp_q == C_BLU);
  assign ram_waddr = ptr_q;
  assign ram_wdata = {red_q, grn_q, lane};

  for (genvar k = 0; k < CTL_COUNT; k++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst)
        ctl_q[k] <= COMP_W'(ctl_init(k));
      else if (wr_ctrl && (ptr_q == IDX_W'(CTL_BASE + k)))
        ctl_q[k] <= lane;
    end
  end

  assign rmask = ctl_q[0];
  assign blink = ctl_q[1];
  assign cmd   = ctl_q[2];
  assign test  = ctl_q[3];

  a_r4_ptr_advance: assert property (@(posedge clk) disable iff (rst)
    (wr_cmap && comp_q == C_BLU) |=> (ptr_q == $past(ptr_q) + 1'b1) && (comp_q == C_RED));

  a_r5_comp_restart: assert property (@(posedge clk) disable iff (rst)
    wr_ptr |=> (comp_q == C_RED) && (ptr_q == $past(IDX_W'(lane))));

  a_r3_comp_legal: assert property (@(posedge clk) disable iff (rst)
    comp_q != 2'd3);

  a_r6_ctl_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && (ptr_q < IDX_W'(CTL_BASE) || ptr_q >= IDX_W'(CTL_BASE + CTL_COUNT)))
      |=> $stable(rmask) && $stable(blink) && $stable(cmd) && $stable(test));

  a_r11_unused_sel: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel == SEL_NONE) |=> $stable(ptr_q) && $stable(comp_q));
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 24,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual port, read-first: a same-address read sees the old word.
  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_pixel_out.sv
module pal_pixel_out #(
  parameter int IDX_W = 8,
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] pix_idx,
  input  logic             video_en,
  input  logic [IDX_W-1:0] rmask,
  output logic [IDX_W-1:0] ram_raddr,
  input  logic [RGB_W-1:0] ram_rdata,
  output logic [RGB_W-1:0] rgb
);
  logic en_q;

  assign ram_raddr = pix_idx & rmask;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= video_en;
  end

  assign rgb = en_q ? ram_rdata : '0;

  a_r9_blank_black: assert property (@(posedge clk) disable iff (rst)
    !video_en |=> (rgb == '0));
endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import pal_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int COMP_W = 8,
  parameter int IDX_W  = 8,
  localparam int RGB_W = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_sel,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [IDX_W-1:0]  pix_idx,
  input  logic              video_en,
  output logic [RGB_W-1:0]  rgb_out,
  output logic [COMP_W-1:0] ctl_rmask,
  output logic [COMP_W-1:0] ctl_blink,
  output logic [COMP_W-1:0] ctl_cmd,
  output logic [COMP_W-1:0] ctl_test
);
  logic             ram_we;
  logic [IDX_W-1:0] ram_waddr, ram_raddr;
  logic [RGB_W-1:0] ram_wdata, ram_rdata;

  pal_regport #(.BUS_W(BUS_W), .COMP_W(COMP_W), .IDX_W(IDX_W)) u_regport (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .rmask(ctl_rmask), .blink(ctl_blink), .cmd(ctl_cmd), .test(ctl_test)
  );

  pal_ram #(.ADDR_W(IDX_W), .DATA_W(RGB_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  pal_pixel_out #(.IDX_W(IDX_W), .RGB_W(RGB_W)) u_pix (
    .clk(clk), .rst(rst), .pix_idx(pix_idx), .video_en(video_en),
    .rmask(IDX_W'(ctl_rmask)), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .rgb(rgb_out)
  );
endmodule

// File: tb/palette_dac_tb.sv
module palette_dac_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  pix_idx = '0;
  logic        video_en = 1'b0;
  logic [23:0] rgb_out;
  logic [7:0]  ctl_rmask, ctl_blink, ctl_cmd, ctl_test;

  int n_cmp = 0;
  int n_bad = 0;
  logic [23:0] model [256];
  logic [23:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  palette_dac u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .pix_idx(pix_idx), .video_en(video_en), .rgb_out(rgb_out),
    .ctl_rmask(ctl_rmask), .ctl_blink(ctl_blink), .ctl_cmd(ctl_cmd), .ctl_test(ctl_test)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus write; low 24 bits carry junk to exercise R2.
  task automatic wr(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = s; bus_wdata = {v, 24'hC3A51E ^ {3{v}}};
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic look(input logic [7:0] idx, input logic en);
    pix_idx = idx; video_en = en;
    @(negedge clk);
    got = rgb_out;
  endtask

  function automatic logic [23:0] gen(input int i);
    return {8'(i), 8'(i * 7 + 3), ~8'(i)};
  endfunction

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rmask", 24'(ctl_rmask), 24'hFF);
    check("R1 blink", 24'(ctl_blink), 24'h00);
    check("R1 cmd",   24'(ctl_cmd),   24'h73);
    check("R1 test",  24'(ctl_test),  24'h00);
    check("R1 rgb",   rgb_out, 24'h0);

    // R3/R4/R2: fill all entries from one pointer write
    wr(2'd0, 8'd0);
    for (int i = 0; i < 256; i++) begin
      model[i] = gen(i);
      wr(2'd1, model[i][23:16]);
      wr(2'd1, model[i][15:8]);
      wr(2'd1, model[i][7:0]);
    end
    for (int i = 0; i < 256; i++) begin
      look(8'(i), 1'b1);
      check("R3 sweep", got, model[i]);
    end

    // R4 wrap: pointer is at 0 again
    wr(2'd1, 8'h11); wr(2'd1, 8'h22); wr(2'd1, 8'h33);
    model[0] = 24'h112233;
    look(8'd0, 1'b1);
    check("R4 wrap", got, model[0]);

    // R5: restart sequence on pointer write
    wr(2'd0, 8'd10); wr(2'd1, 8'hAA); wr(2'd1, 8'hBB);
    wr(2'd0, 8'd20); wr(2'd1, 8'h01); wr(2'd1, 8'h02); wr(2'd1, 8'h03);
    model[20] = 24'h010203;
    look(8'd10, 1'b1);
    check("R5 untouched", got, model[10]);
    look(8'd20, 1'b1);
    check("R5 restart", got, model[20]);

    // R11: sel 3 mid-sequence
    wr(2'd0, 8'd30); wr(2'd1, 8'h44); wr(2'd3, 8'h99); wr(2'd1, 8'h55); wr(2'd1, 8'h66);
    model[30] = 24'h445566;
    look(8'd30, 1'b1);
    check("R11 seq", got, model[30]);
    look(8'd31, 1'b1);
    check("R11 next", got, model[31]);
    check("R11 ctl", {ctl_blink, ctl_cmd, ctl_test}, 24'h007300);

    // R6 control registers
    wr(2'd0, 8'd5); wr(2'd2, 8'h5C);
    wr(2'd0, 8'd6); wr(2'd2, 8'h81);
    wr(2'd0, 8'd7); wr(2'd2, 8'hE7);
    check("R6 blink", 24'(ctl_blink), 24'h5C);
    check("R6 cmd",   24'(ctl_cmd),   24'h81);
    check("R6 test",  24'(ctl_test),  24'hE7);
    wr(2'd0, 8'd9); wr(2'd2, 8'h00);
    wr(2'd0, 8'd3); wr(2'd2, 8'h00);
    check("R6 ignored", {ctl_blink, ctl_cmd, ctl_test}, 24'h5C81E7);
    check("R6 mask kept", 24'(ctl_rmask), 24'hFF);

    // R7 read mask
    wr(2'd0, 8'd4); wr(2'd2, 8'h0F);
    check("R6 rmask", 24'(ctl_rmask), 24'h0F);
    for (int i = 0; i < 256; i += 17) begin
      look(8'(i) | 8'hA0, 1'b1);
      check("R7 masked", got, model[(i | 8'hA0) & 8'h0F]);
    end
    wr(2'd0, 8'd4); wr(2'd2, 8'hFF);

    // R8 latency
    look(8'd50, 1'b1);
    pix_idx = 8'd51;
    #1;
    check("R8 hold", rgb_out, model[50]);
    @(negedge clk);
    check("R8 update", rgb_out, model[51]);

    // R9 blanking
    look(8'd200, 1'b0);
    check("R9 black", got, 24'h0);
    look(8'd200, 1'b1);
    check("R9 resume", got, model[200]);

    // R10 same-cycle write and lookup
    wr(2'd0, 8'd40); wr(2'd1, 8'hDE); wr(2'd1, 8'hAD);
    bus_wr = 1'b1; bus_sel = 2'd1; bus_wdata = {8'hBF, 24'h0};
    pix_idx = 8'd40; video_en = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R10 old", rgb_out, model[40]);
    model[40] = 24'hDEADBF;
    @(negedge clk);
    check("R10 new", rgb_out, model[40]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule